// File: doc/BRIEF.md
# Anticollision Identifier Response Generator

This block builds the identifier frame a contactless card returns while a reader runs anticollision and select. It is given the cascade level the reader is asking for, the card's stored identifier, the identifier length and random-identifier configuration, the card's current security level and a 24-bit random source. When a request is accepted it returns five bytes, four identifier bytes and a check byte, together with a one-cycle valid strobe.

A card can hold a 4-byte non-unique identifier or a 7-byte unique identifier. The length is fixed when the card is made. A 7-byte identifier is spread over two cascade levels. A card that has been configured for random identifiers, and that runs at the highest security level, hides its stored identifier during anticollision. In its place it sends a tag byte and three random bytes. These random bytes are drawn once per activation, so every repeated request in the same activation returns the same value. The stored identifier is an input only and the block never writes it. Other paths can still read it.

Top module: `uid_resp_gen`

## Requirements
- R1: After reset `resp_vld` is 0 and `resp` is all zero.
- R2: When `req` is sampled high and a response applies, `resp_vld` is high for exactly the next cycle and `resp` holds the frame. `resp[7:0]` is the first byte sent and `resp[39:32]` is the check byte. A cycle with no `req` gives no strobe.
- R3: With a 4-byte identifier (`uid_long`=0) at cascade level 1 (`casc_lvl`=0), the four data bytes are `uid[7:0]`, `uid[15:8]`, `uid[23:16]`, `uid[31:24]`, in that order.
- R4: With a 7-byte identifier (`uid_long`=1) at cascade level 1, the data bytes are the cascade tag 88h followed by `uid[7:0]`, `uid[15:8]`, `uid[23:16]`.
- R5: With a 7-byte identifier at cascade level 2 (`casc_lvl`=1), the data bytes are `uid[31:24]`, `uid[39:32]`, `uid[47:40]`, `uid[55:48]`.
- R6: The check byte equals the XOR of the four data bytes of the same frame.
- R7: A cascade level 2 request gives no response when the identifier is 4 bytes long or when random-identifier mode is in effect.
- R8: Random-identifier mode is in effect only when `rid_en`=1 and `sec_lvl`=3. When `rid_en`=1 at any other level, the fixed identifier is returned.
- R9: In random-identifier mode a level 1 frame carries the tag 08h followed by `rnd_in[7:0]`, `rnd_in[15:8]`, `rnd_in[23:16]`, taken at the first accepted request of the activation. Later requests in the same activation return those same three bytes, whatever `rnd_in` holds at that time.
- R10: A `halt` pulse, or `field_on` going low, ends the activation. The next random-identifier request then takes fresh bytes from `rnd_in`.
- R11: While `field_on` is low, requests give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_on | input | 1 | Card powered by the reader field; low ends the activation |
| halt | input | 1 | One-cycle pulse: halt received, ends the activation |
| req | input | 1 | One-cycle pulse: anticollision/select request |
| casc_lvl | input | 1 | Requested cascade level: 0 = level 1, 1 = level 2 |
| uid_long | input | 1 | Identifier length: 0 = 4 bytes, 1 = 7 bytes |
| rid_en | input | 1 | Random-identifier configuration bit |
| sec_lvl | input | 2 | Current security level (0, 1 or 3) |
| uid | input | 56 | Stored identifier, byte 0 in bits 7:0 |
| rnd_in | input | 24 | Random byte source, three bytes |
| resp_vld | output | 1 | Frame valid strobe |
| resp | output | 40 | Frame: data bytes 0..3 in bits 31:0, check byte in bits 39:32 |

## Verification
Faults in the held random bytes or in the held flag are hidden on the first request of an activation. They only appear on a second request in the same activation, or on the first request after a halt or a field drop. The bench therefore repeats requests while `rnd_in` changes in between. A wrong frame selection, such as the wrong level decode or a missing cascade tag, shows up in the frame one cycle after the request. An error in mode gating shows up as a strobe where none should be, or as a fixed identifier where a random one is due.

// File: rtl/uid_resp_gen.sv
module uid_resp_gen #(
  parameter logic [7:0] CASC_TAG = 8'h88,
  parameter logic [7:0] RID_TAG  = 8'h08,
  parameter int         SLW      = 2,
  parameter int         RID_SL   = 3,
  parameter int         NB       = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_on,
  input  logic            halt,
  input  logic            req,
  input  logic            casc_lvl,
  input  logic            uid_long,
  input  logic            rid_en,
  input  logic [SLW-1:0]  sec_lvl,
  input  logic [NB*8-1:0] uid,
  input  logic [23:0]     rnd_in,
  output logic            resp_vld,
  output logic [39:0]     resp
);
  localparam logic [SLW-1:0] RID_LVL = SLW'(RID_SL);

  logic        rid_mode;
  logic        rid_held;
  logic [23:0] rid_q;
  logic [23:0] rid_now;
  logic [31:0] body;
  logic        ok;
  logic [7:0]  bcc;

  assign rid_mode = rid_en && (sec_lvl == RID_LVL);
  assign rid_now  = rid_held ? rid_q : rnd_in;
  assign bcc      = body[7:0] ^ body[15:8] ^ body[23:16] ^ body[31:24];

  always_comb begin
    ok   = field_on;
    body = '0;
    if (rid_mode) begin
      if (casc_lvl) ok = 1'b0;
      else          body = {rid_now, RID_TAG};
    end else if (uid_long) begin
      if (casc_lvl) body = uid[55:24];
      else          body = {uid[23:0], CASC_TAG};
    end else begin
      if (casc_lvl) ok = 1'b0;
      else          body = uid[31:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_vld <= 1'b0;
      resp     <= '0;
      rid_held <= 1'b0;
      rid_q    <= '0;
    end else begin
      resp_vld <= req && ok;
      if (req && ok) resp <= {bcc, body};
      if (!field_on || halt) begin
        rid_held <= 1'b0;
      end else if (req && ok && rid_mode) begin
        rid_held <= 1'b1;
        rid_q    <= rid_now;
      end
    end
  end
endmodule

// File: rtl/uid_resp_gen_chk.sv
module uid_resp_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        field_on,
  input logic        req,
  input logic        casc_lvl,
  input logic        uid_long,
  input logic        rid_en,
  input logic [1:0]  sec_lvl,
  input logic [55:0] uid,
  input logic        resp_vld,
  input logic [39:0] resp
);
  a_r2_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> $past(req));

  a_r6_check_byte: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> resp[39:32] == (resp[7:0] ^ resp[15:8] ^ resp[23:16] ^ resp[31:24]));

  a_r7_short_no_l2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && casc_lvl && !uid_long) |=> !resp_vld);

  a_r4_casc_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (req && field_on && !casc_lvl && uid_long && sec_lvl != 2'd3) |=> resp_vld && resp[7:0] == 8'h88);

  a_r8_fixed_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    (req && field_on && !casc_lvl && !uid_long && rid_en && sec_lvl != 2'd3) |=> resp_vld && resp[7:0] == $past(uid[7:0]));

  a_r11_no_field: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !field_on) |=> !resp_vld);
endmodule

bind uid_resp_gen uid_resp_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .field_on(field_on), .req(req), .casc_lvl(casc_lvl),
  .uid_long(uid_long), .rid_en(rid_en), .sec_lvl(sec_lvl), .uid(uid),
  .resp_vld(resp_vld), .resp(resp)
);

// File: tb/tb_uid_resp_gen.sv
module tb_uid_resp_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_on = 1'b0;
  logic        halt = 1'b0;
  logic        req = 1'b0;
  logic        casc_lvl = 1'b0;
  logic        uid_long = 1'b0;
  logic        rid_en = 1'b0;
  logic [1:0]  sec_lvl = 2'd0;
  logic [55:0] uid = 56'h07F6E5D4C3B2A1;
  logic [23:0] rnd_in = 24'h0;
  logic        resp_vld;
  logic [39:0] resp;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uid_resp_gen dut (
    .clk(clk), .rst_n(rst_n), .field_on(field_on), .halt(halt), .req(req),
    .casc_lvl(casc_lvl), .uid_long(uid_long), .rid_en(rid_en), .sec_lvl(sec_lvl),
    .uid(uid), .rnd_in(rnd_in), .resp_vld(resp_vld), .resp(resp)
  );

  function automatic logic [39:0] frame(input logic [7:0] b0, b1, b2, b3);
    return {b0 ^ b1 ^ b2 ^ b3, b3, b2, b1, b0};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ask(input logic lvl, output logic v, output logic [39:0] d);
    @(negedge clk);
    casc_lvl = lvl;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    v = resp_vld;
    d = resp;
    @(negedge clk);
    check("R2 strobe single cycle", 64'(resp_vld), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 reset vld", 64'(resp_vld), 64'd0);
    check("R1 reset data", 64'(resp), 64'd0);
  endtask

  task automatic t_short();
    logic v; logic [39:0] d;
    uid_long = 1'b0; rid_en = 1'b0; sec_lvl = 2'd1;
    ask(1'b0, v, d);
    check("R3 short l1 vld", 64'(v), 64'd1);
    check("R3 R6 short l1 frame", 64'(d), 64'(frame(8'hA1, 8'hB2, 8'hC3, 8'hD4)));
    ask(1'b1, v, d);
    check("R7 short l2 none", 64'(v), 64'd0);
  endtask

  task automatic t_long();
    logic v; logic [39:0] d;
    uid_long = 1'b1; rid_en = 1'b0; sec_lvl = 2'd3;
    ask(1'b0, v, d);
    check("R4 long l1 vld", 64'(v), 64'd1);
    check("R4 R6 long l1 frame", 64'(d), 64'(frame(8'h88, 8'hA1, 8'hB2, 8'hC3)));
    ask(1'b1, v, d);
    check("R5 long l2 vld", 64'(v), 64'd1);
    check("R5 R6 long l2 frame", 64'(d), 64'(frame(8'hD4, 8'hE5, 8'hF6, 8'h07)));
  endtask

  task automatic t_rid_gated();
    logic v; logic [39:0] d;
    uid_long = 1'b0; rid_en = 1'b1; sec_lvl = 2'd1; rnd_in = 24'h123456;
    ask(1'b0, v, d);
    check("R8 sl1 fixed id", 64'(d), 64'(frame(8'hA1, 8'hB2, 8'hC3, 8'hD4)));
    sec_lvl = 2'd0;
    ask(1'b0, v, d);
    check("R8 sl0 fixed id", 64'(d), 64'(frame(8'hA1, 8'hB2, 8'hC3, 8'hD4)));
  endtask

  task automatic t_rid();
    logic v; logic [39:0] d;
    uid_long = 1'b1; rid_en = 1'b1; sec_lvl = 2'd3; rnd_in = 24'h5A3C7E;
    ask(1'b0, v, d);
    check("R9 rid vld", 64'(v), 64'd1);
    check("R9 R6 rid frame", 64'(d), 64'(frame(8'h08, 8'h7E, 8'h3C, 8'h5A)));
    rnd_in = 24'hFFEEDD;
    ask(1'b0, v, d);
    check("R9 rid held", 64'(d), 64'(frame(8'h08, 8'h7E, 8'h3C, 8'h5A)));
    ask(1'b1, v, d);
    check("R7 rid l2 none", 64'(v), 64'd0);
  endtask

  task automatic t_renew();
    logic v; logic [39:0] d;
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0; rnd_in = 24'h0B0A09;
    ask(1'b0, v, d);
    check("R10 fresh after halt", 64'(d), 64'(frame(8'h08, 8'h09, 8'h0A, 8'h0B)));
    field_on = 1'b0;
    ask(1'b0, v, d);
    check("R11 no field none", 64'(v), 64'd0);
    field_on = 1'b1; rnd_in = 24'h332211;
    ask(1'b0, v, d);
    check("R10 fresh after field drop", 64'(d), 64'(frame(8'h08, 8'h11, 8'h22, 8'h33)));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        field_on = 1'b1;
        t_short();
        t_long();
        t_rid_gated();
        t_rid();
        t_renew();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule